// File: doc/BRIEF.md
# RTC Periodic Interrupt Output Generator

This block produces the active-low interrupt pin of a real-time clock. It has three sources: a once-per-second rollover strobe, a once-per-minute increment strobe and a watchdog-expired level. Each enabled second or minute event sets a sticky event flag. Software clears that flag with a one-cycle clear strobe. A select bit picks how the flag reaches the pin. In pulse mode, each enabled event starts a short low pulse that is timed by a 64 Hz tick strobe. In level mode, the pin stays low for as long as the flag is set and at least one periodic source is enabled.

The watchdog source never pulses. When its enable is set, the pin follows the watchdog level in both modes. Clearing the flag ends a pulse early, so the interrupt handler does not have to wait out the pulse. Every effect appears on the pin one clock after its cause, because the pin is driven from a register.

Top module: `rtc_irq_gen`

## Requirements
- R1: An event sets the flag on the next clock when it is enabled: `sec_roll` with `sec_irq_en` set, or `min_step` with `min_irq_en` set. An event whose enable is clear sets nothing and leaves `irq_n` unchanged.
- R2: With no enabled event in the same cycle, `evt_flag_clr` clears the flag on the next clock. In level mode `irq_n` then returns high, unless the watchdog is driving it.
- R3: In pulse mode (`pulse_sel`=1), an enabled event drives `irq_n` low from the next clock. The pulse ends at the second `tick_64hz` strobe after the event, so it covers one full tick interval. `irq_n` goes high on the clock after that strobe.
- R4: `evt_flag_clr` during a pulse ends the pulse. `irq_n` is high on the next clock unless the watchdog is driving it.
- R5: In level mode (`pulse_sel`=0), `irq_n` is low while the flag is set and `sec_irq_en` or `min_irq_en` is set. Clearing both enables releases the pin on the next clock and leaves the flag set.
- R6: With `wdog_irq_en` set, `irq_n` is low on the clock after `wdog_expired` is high and follows that level in either mode. It is never shortened to a pulse.
- R7: When a clear strobe and an enabled event arrive in the same cycle, the flag stays set but no pulse starts. The next enabled event starts a fresh pulse.
- R8: Synchronous active-high `rst` clears the flag and any pulse. `irq_n` is high on the clock after `rst` is sampled.
- R9: An enabled event during a pulse restarts the pulse timing. The pulse then ends at the second tick strobe after the new event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_64hz | input | 1 | One-cycle strobe at 64 Hz |
| sec_roll | input | 1 | One-cycle strobe on each seconds rollover |
| min_step | input | 1 | One-cycle strobe on each minutes increment |
| wdog_expired | input | 1 | Watchdog expiry flag (level) |
| sec_irq_en | input | 1 | Enable for the second source |
| min_irq_en | input | 1 | Enable for the minute source |
| wdog_irq_en | input | 1 | Enable for the watchdog source |
| pulse_sel | input | 1 | 1 = pulse mode, 0 = level mode |
| evt_flag_clr | input | 1 | One-cycle strobe that clears the event flag |
| irq_n | output | 1 | Registered active-low interrupt output |

## Verification
The clear strobe and a new enabled event can fall in the same cycle, and so can a tick strobe and an event. In that case the clear must win for the pulse while the event wins for the flag, and an event that arrives with a tick must restart the tick count. The bench forces both collisions directly. It then switches to level mode to expose the flag that the clear left set. Random stimulus runs over many cycles and produces further collisions. A bench-side reference model, written from the requirements, judges the pin on every cycle.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;

    typedef enum logic {
        IRQ_LEVEL = 1'b0,
        IRQ_PULSE = 1'b1
    } irq_mode_e;

    typedef struct packed {
        logic sec_roll;
        logic min_step;
        logic sec_en;
        logic min_en;
    } periodic_src_t;

    function automatic logic periodic_hit(input periodic_src_t s);
        return (s.sec_roll & s.sec_en) | (s.min_step & s.min_en);
    endfunction

    function automatic logic any_periodic_en(input periodic_src_t s);
        return s.sec_en | s.min_en;
    endfunction

endpackage

// File: rtl/rtc_irq_flag.sv
module rtc_irq_flag (
    input  logic clk,
    input  logic rst,
    input  logic hit,
    input  logic clr,
    output logic flag_nxt,
    output logic flag_q
);

    typedef struct packed {
        logic flag;
    } flag_state_t;

    flag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (hit) begin
            st_d.flag = 1'b1;
        end else if (clr) begin
            st_d.flag = 1'b0;
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign flag_nxt = st_d.flag;
    assign flag_q   = st_q.flag;

    // R1: an enabled event always leaves the flag set
    a_r1_hit_sets_flag: assert property (@(posedge clk) disable iff (rst)
        hit |=> flag_q);

    // R2: a lone clear drops the flag
    a_r2_clr_drops_flag: assert property (@(posedge clk) disable iff (rst)
        (clr && !hit) |=> !flag_q);

endmodule

// File: rtl/rtc_irq_pulse.sv
module rtc_irq_pulse #(
    parameter int PULSE_TICKS = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic hit,
    input  logic clr,
    input  logic tick,
    output logic pulse_nxt,
    output logic pulse_q
);

    localparam int CNT_W = (PULSE_TICKS < 2) ? 1 : $clog2(PULSE_TICKS + 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(PULSE_TICKS);

    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] ticks;
    } pulse_state_t;

    pulse_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d = '0;
        end else if (hit) begin
            st_d.active = 1'b1;
            st_d.ticks  = '0;
        end else if (st_q.active && tick) begin
            if (st_q.ticks == LAST_CNT) begin
                st_d = '0;
            end else begin
                st_d.ticks = st_q.ticks + 1'b1;
            end
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign pulse_nxt = st_d.active;
    assign pulse_q   = st_q.active;

    // R4: a clear always ends the pulse
    a_r4_clr_ends_pulse: assert property (@(posedge clk) disable iff (rst)
        clr |=> !pulse_q);

    // R3: an enabled event without clear starts a pulse
    a_r3_hit_starts_pulse: assert property (@(posedge clk) disable iff (rst)
        (hit && !clr) |=> pulse_q);

    // R3: a pulse with no tick, clear or event keeps going
    a_r3_pulse_holds: assert property (@(posedge clk) disable iff (rst)
        (pulse_q && !tick && !clr && !hit) |=> pulse_q);

endmodule

// File: rtl/rtc_irq_out.sv
module rtc_irq_out
    import rtc_irq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  irq_mode_e mode,
    input  logic      flag_nxt,
    input  logic      pulse_nxt,
    input  logic      periodic_en,
    input  logic      wdog_level,
    output logic      irq_n
);

    typedef struct packed {
        logic irq_n;
    } out_state_t;

    out_state_t st_d, st_q;
    logic       periodic_irq;

    always_comb begin
        if (mode == IRQ_PULSE) begin
            periodic_irq = pulse_nxt;
        end else begin
            periodic_irq = flag_nxt & periodic_en;
        end
        st_d.irq_n = ~(periodic_irq | wdog_level);
        if (rst) begin
            st_d.irq_n = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign irq_n = st_q.irq_n;

    // R8: reset leaves the pin inactive
    a_r8_reset_idle: assert property (@(posedge clk)
        rst |=> irq_n);

    // R6: an enabled watchdog level always pulls the pin low
    a_r6_wdog_level: assert property (@(posedge clk) disable iff (rst)
        wdog_level |=> !irq_n);

endmodule

// File: rtl/rtc_irq_gen.sv
module rtc_irq_gen
    import rtc_irq_pkg::*;
#(
    parameter int PULSE_TICKS = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_64hz,
    input  logic sec_roll,
    input  logic min_step,
    input  logic wdog_expired,
    input  logic sec_irq_en,
    input  logic min_irq_en,
    input  logic wdog_irq_en,
    input  logic pulse_sel,
    input  logic evt_flag_clr,
    output logic irq_n
);

    periodic_src_t src;
    logic          hit;
    logic          flag_nxt, flag_q;
    logic          pulse_nxt, pulse_q;
    logic          wdog_level;
    irq_mode_e     mode;

    always_comb begin
        src.sec_roll = sec_roll;
        src.min_step = min_step;
        src.sec_en   = sec_irq_en;
        src.min_en   = min_irq_en;
        hit          = periodic_hit(src);
        wdog_level   = wdog_irq_en & wdog_expired;
        mode         = irq_mode_e'(pulse_sel);
    end

    rtc_irq_flag u_flag (
        .clk      (clk),
        .rst      (rst),
        .hit      (hit),
        .clr      (evt_flag_clr),
        .flag_nxt (flag_nxt),
        .flag_q   (flag_q)
    );

    rtc_irq_pulse #(
        .PULSE_TICKS (PULSE_TICKS)
    ) u_pulse (
        .clk       (clk),
        .rst       (rst),
        .hit       (hit),
        .clr       (evt_flag_clr),
        .tick      (tick_64hz),
        .pulse_nxt (pulse_nxt),
        .pulse_q   (pulse_q)
    );

    rtc_irq_out u_out (
        .clk         (clk),
        .rst         (rst),
        .mode        (mode),
        .flag_nxt    (flag_nxt),
        .pulse_nxt   (pulse_nxt),
        .periodic_en (any_periodic_en(src)),
        .wdog_level  (wdog_level),
        .irq_n       (irq_n)
    );

    // R7: a clear that meets an event keeps the flag but starts no pulse
    a_r7_clr_event_same_cycle: assert property (@(posedge clk) disable iff (rst)
        (hit && evt_flag_clr) |=> (flag_q && !pulse_q));

    // R5: level mode with every source silent leaves the pin high
    a_r5_level_release: assert property (@(posedge clk) disable iff (rst)
        (!pulse_sel && !sec_irq_en && !min_irq_en && !(wdog_irq_en && wdog_expired))
        |=> irq_n);

    // R3: in pulse mode a running pulse holds the pin low
    a_r3_pulse_on_pin: assert property (@(posedge clk) disable iff (rst)
        (pulse_sel && pulse_nxt) |=> !irq_n);

endmodule

// File: tb/rtc_irq_gen_test.sv
module rtc_irq_gen_test;

    localparam int PT       = 1;
    localparam int TICK_DIV = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick_64hz = 0, sec_roll = 0, min_step = 0, wdog_expired = 0;
    logic sec_irq_en = 0, min_irq_en = 0, wdog_irq_en = 0, pulse_sel = 0, evt_flag_clr = 0;
    logic irq_n;

    int checks = 0;
    int errors = 0;
    int ncyc   = 0;
    bit done   = 0;

    bit m_flag = 0, m_pulse = 0, m_irqn = 1;
    int m_ticks = 0;

    always #2.5 clk = ~clk;

    rtc_irq_gen #(.PULSE_TICKS(PT)) uut (
        .clk(clk), .rst(rst), .tick_64hz(tick_64hz), .sec_roll(sec_roll),
        .min_step(min_step), .wdog_expired(wdog_expired), .sec_irq_en(sec_irq_en),
        .min_irq_en(min_irq_en), .wdog_irq_en(wdog_irq_en), .pulse_sel(pulse_sel),
        .evt_flag_clr(evt_flag_clr), .irq_n(irq_n)
    );

    function automatic bit expect_irqn(bit flag, bit pulse);
        bit periodic;
        periodic = pulse_sel ? pulse : (flag && (sec_irq_en || min_irq_en));
        return !(periodic || (wdog_irq_en && wdog_expired));
    endfunction

    task automatic model_step();
        bit ev;
        ev = (sec_roll && sec_irq_en) || (min_step && min_irq_en);
        if (rst) begin
            m_flag = 0; m_pulse = 0; m_ticks = 0; m_irqn = 1;
        end else begin
            if (ev) m_flag = 1;
            else if (evt_flag_clr) m_flag = 0;
            if (evt_flag_clr) begin
                m_pulse = 0; m_ticks = 0;
            end else if (ev) begin
                m_pulse = 1; m_ticks = 0;
            end else if (m_pulse && tick_64hz) begin
                m_ticks++;
                if (m_ticks > PT) begin m_pulse = 0; m_ticks = 0; end
            end
            m_irqn = expect_irqn(m_flag, m_pulse);
        end
    endtask

    task automatic cyc(string req, bit rand_tick = 0);
        tick_64hz = rand_tick ? ($urandom % 5 == 0) : (ncyc % TICK_DIV == TICK_DIV - 1);
        model_step();
        @(posedge clk);
        #1;
        ncyc++;
        checks++;
        if (irq_n !== m_irqn) begin
            errors++;
            $display("FAIL %s cycle %0d irq_n actual %b expected %b", req, ncyc, irq_n, m_irqn);
        end
        sec_roll = 0; min_step = 0; evt_flag_clr = 0;
    endtask

    task automatic run(string req, int n);
        for (int i = 0; i < n; i++) cyc(req);
    endtask

    initial begin
        void'($urandom(32'd4242));
        rst = 1;
        run("R8", 3);
        rst = 0;

        // R3: pulse from a second event, ends at second tick
        pulse_sel = 1; sec_irq_en = 1;
        sec_roll = 1; cyc("R3");
        run("R3", 2 * TICK_DIV + 4);

        // R1: disabled minute event does nothing
        min_step = 1; cyc("R1");
        run("R1", 4);

        // R4: clear cuts a pulse short
        sec_roll = 1; cyc("R4");
        run("R4", 3);
        evt_flag_clr = 1; cyc("R4");
        run("R4", 4);

        // R9: second event during pulse restarts timing
        sec_roll = 1; cyc("R9");
        run("R9", TICK_DIV + 2);
        sec_roll = 1; cyc("R9");
        run("R9", 2 * TICK_DIV + 2);

        // R7: clear and event collide, then inspect flag in level mode
        evt_flag_clr = 1; sec_roll = 1; cyc("R7");
        run("R7", 3);
        pulse_sel = 0; cyc("R7");
        run("R7", 2);
        pulse_sel = 1; sec_roll = 1; cyc("R7");
        run("R7", 3);

        // R5: level mode follows flag, released by disabling enables
        pulse_sel = 0; min_irq_en = 1; sec_irq_en = 0;
        min_step = 1; cyc("R5");
        run("R5", 3 * TICK_DIV);
        min_irq_en = 0; cyc("R5");
        run("R5", 3);
        // R2: clear ends level interrupt
        min_irq_en = 1; cyc("R2");
        evt_flag_clr = 1; cyc("R2");
        run("R2", 3);

        // R6: watchdog level in pulse mode, never a pulse
        pulse_sel = 1; wdog_irq_en = 1; wdog_expired = 1; cyc("R6");
        run("R6", 4 * TICK_DIV);
        wdog_expired = 0; cyc("R6");
        run("R6", 2);
        wdog_irq_en = 0; wdog_expired = 1; run("R6", 3);
        wdog_expired = 0;

        // R8: reset in the middle of a pulse
        sec_irq_en = 1; sec_roll = 1; cyc("R8");
        run("R8", 2);
        rst = 1; cyc("R8");
        rst = 0; run("R8", 3);

        // random mix
        for (int i = 0; i < 4000; i++) begin
            sec_roll     = ($urandom % 23 == 0);
            min_step     = ($urandom % 61 == 0);
            evt_flag_clr = ($urandom % 19 == 0);
            if ($urandom % 97 == 0) pulse_sel   = ~pulse_sel;
            if ($urandom % 131 == 0) sec_irq_en = ~sec_irq_en;
            if ($urandom % 151 == 0) min_irq_en = ~min_irq_en;
            if ($urandom % 211 == 0) wdog_irq_en = ~wdog_irq_en;
            if ($urandom % 89 == 0) wdog_expired = ~wdog_expired;
            rst = ($urandom % 1500 == 0);
            cyc(pulse_sel ? "R3" : "R5", 1'b1);
        end
        rst = 0;

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired at cycle %0d actual running expected finished", ncyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule